// File: doc/BRIEF.md
# DMA Request Arbiter

This block sits between four peripheral DMA request lines and the host processor's bus-release handshake. When any enabled channel raises its request, the arbiter asks the processor for the bus with a hold request. It then waits for the hold acknowledge before it picks a winner and drives that channel's active-low acknowledge. The granted channel index also goes to a transfer sequencer, which drives the bus cycles and pulses a done strobe at the end of each transfer.

Two priority schemes are available, chosen at run time by a single mode input. In the fixed scheme the lowest channel number always wins. In the rotating scheme the channel served last drops to the bottom of the order. A per-channel enable mask is cleared by reset and loaded as a whole through a load strobe. Requests on disabled channels are ignored. A grant is never changed while a transfer is in progress. After the arbiter lets go of the bus, it does not ask again until the processor has dropped its acknowledge.

Top module: `dma_req_arbiter`

## Requirements
- R1: Each of the four request inputs `dreq_i[c]` can be granted; while `grant_valid_o` is high, `grant_idx_o` holds the binary number c of the served channel.
- R2: When `rotate_i` is 0, the enabled pending channel with the smallest number wins each arbitration.
- R3: When `rotate_i` is 1, the search starts at the channel after the one served last (wrapping from 3 to 0), so the served channel becomes lowest priority; after reset the last-served pointer is channel 3, so channel 0 ranks first.
- R4: `hold_req_o` rises one clock after an enabled request is present in the idle state (with `hold_ack_i` low); no acknowledge is driven until `hold_ack_i` has been seen high at a clock edge.
- R5: `dack_n_o` is all ones except while a grant is held, when exactly the bit of the granted channel is 0.
- R6: Reset clears the enable mask, so no request is honoured; a clock edge with `mask_load_i` high copies `mask_val_i` into the mask (bit c enables channel c), effective from the next edge.
- R7: Once granted, the channel and its acknowledge stay unchanged until `xfer_done_i` is seen high; request and mask changes in between have no effect on the grant.
- R8: A request on a channel whose mask bit is 0 never raises `hold_req_o` and is never granted.
- R9: When no enabled request remains (while waiting for the acknowledge or at the end of a transfer), `hold_req_o` falls on the next edge and is not raised again until `hold_ack_i` has been low at an edge.
- R10: If an enabled request is pending at the edge where `xfer_done_i` is high and `hold_ack_i` is still high, the next grant takes effect at that same edge, with `hold_req_o` and `grant_valid_o` staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| dreq_i | input | 4 | Per-channel DMA request, active high |
| mask_load_i | input | 1 | Load strobe for the enable mask |
| mask_val_i | input | 4 | New enable mask, bit c enables channel c |
| rotate_i | input | 1 | 0 selects fixed priority, 1 selects rotating priority |
| hold_ack_i | input | 1 | Bus release acknowledge from the processor |
| xfer_done_i | input | 1 | End-of-transfer strobe from the sequencer |
| hold_req_o | output | 1 | Bus request to the processor |
| dack_n_o | output | 4 | Per-channel acknowledge, active low |
| grant_valid_o | output | 1 | A channel currently holds the grant |
| grant_idx_o | output | 2 | Number of the granted channel |

## Verification
A corrupted last-served pointer shows up at the first rotating arbitration after it goes wrong: the next grant goes to the wrong channel, one clock after the done strobe. A wrong handshake state shows up within a single clock, as a hold request that is missing, comes too early or is re-raised while the acknowledge is still high. A bad mask bit shows up on the first request from that channel, as a hold request or grant that should not appear. The reference model runs in step with the design, so any of these is caught in the cycle where it first reaches a port.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Handshake phase of the arbiter.
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,  // bus not requested
    ARB_ASK   = 2'd1,  // hold request up, waiting for acknowledge
    ARB_OWN   = 2'd2,  // one channel granted
    ARB_YIELD = 2'd3   // request withdrawn, waiting for acknowledge to fall
  } arb_state_e;

endpackage

// File: rtl/dma_arb_enable.sv
module dma_arb_enable #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [NUM_CH-1:0] val_i,
  input  logic [NUM_CH-1:0] dreq_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] eligible_o
);

  // One enable flop per channel, each with its own clock enable.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
    logic bit_q;
    logic bit_d;

    always_comb begin
      bit_d = bit_q;
      if (load_i) begin
        bit_d = val_i[g];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q <= 1'b0;
      end else begin
        bit_q <= bit_d;
      end
    end

    assign en_o[g]       = bit_q;
    assign eligible_o[g] = bit_q & dreq_i[g];
  end

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic              rotate_i,
  input  logic [IDX_W-1:0]  last_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);

  // Search start: 0 in fixed mode, the channel after the last served in
  // rotating mode.
  logic [IDX_W-1:0] start;

  always_comb begin
    int nxt;
    nxt = int'(last_i) + 1;
    if (nxt >= NUM_CH) begin
      nxt = 0;
    end
    start = rotate_i ? IDX_W'(nxt) : '0;
  end

  // Walk the order from lowest to highest priority; the last hit wins,
  // which is the highest-priority pending channel.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      int cand;
      cand = int'(start) + k;
      if (cand >= NUM_CH) begin
        cand = cand - NUM_CH;
      end
      if (req_i[cand]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
  import dma_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       any_req_i,
  input  logic       hold_ack_i,
  input  logic       xfer_done_i,
  output arb_state_e state_o,
  output logic       load_grant_o,
  output logic       retire_o
);

  arb_state_e state_q;
  arb_state_e state_d;

  always_comb begin
    state_d      = state_q;
    load_grant_o = 1'b0;
    retire_o     = 1'b0;
    unique case (state_q)
      ARB_IDLE: begin
        if (any_req_i && !hold_ack_i) begin
          state_d = ARB_ASK;
        end
      end
      ARB_ASK: begin
        if (!any_req_i) begin
          state_d = ARB_YIELD;
        end else if (hold_ack_i) begin
          state_d      = ARB_OWN;
          load_grant_o = 1'b1;
        end
      end
      ARB_OWN: begin
        if (xfer_done_i) begin
          retire_o = 1'b1;
          if (!any_req_i) begin
            state_d = ARB_YIELD;
          end else if (hold_ack_i) begin
            state_d      = ARB_OWN;
            load_grant_o = 1'b1;
          end else begin
            state_d = ARB_ASK;
          end
        end
      end
      ARB_YIELD: begin
        if (!hold_ack_i) begin
          state_d = ARB_IDLE;
        end
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int  NUM_CH = 4,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] dreq_i,
  input  logic              mask_load_i,
  input  logic [NUM_CH-1:0] mask_val_i,
  input  logic              rotate_i,
  input  logic              hold_ack_i,
  input  logic              xfer_done_i,
  output logic              hold_req_o,
  output logic [NUM_CH-1:0] dack_n_o,
  output logic              grant_valid_o,
  output logic [IDX_W-1:0]  grant_idx_o
);

  localparam logic [IDX_W-1:0] LastInit = IDX_W'(NUM_CH - 1);

  logic [NUM_CH-1:0] chan_en;
  logic [NUM_CH-1:0] eligible;
  logic              any_req;
  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic [IDX_W-1:0]  pick_last;
  arb_state_e        state;
  logic              load_grant;
  logic              retire;
  logic              own;

  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_d;
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W-1:0]  last_d;

  dma_arb_enable #(
    .NUM_CH (NUM_CH)
  ) u_enable (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (mask_load_i),
    .val_i      (mask_val_i),
    .dreq_i     (dreq_i),
    .en_o       (chan_en),
    .eligible_o (eligible)
  );

  assign any_req = |eligible;

  dma_arb_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .any_req_i    (any_req),
    .hold_ack_i   (hold_ack_i),
    .xfer_done_i  (xfer_done_i),
    .state_o      (state),
    .load_grant_o (load_grant),
    .retire_o     (retire)
  );

  assign own = (state == ARB_OWN);

  // At the end of a transfer the channel being retired already counts as
  // the last served one for the back-to-back pick.
  assign pick_last = own ? idx_q : last_q;

  dma_arb_pick #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W)
  ) u_pick (
    .req_i    (eligible),
    .rotate_i (rotate_i),
    .last_i   (pick_last),
    .found_o  (pick_found),
    .idx_o    (pick_idx)
  );

  // Granted channel register.
  always_comb begin
    idx_d = idx_q;
    if (load_grant && pick_found) begin
      idx_d = pick_idx;
    end
  end

  // Last-served pointer, updated when a transfer retires.
  always_comb begin
    last_d = last_q;
    if (retire) begin
      last_d = idx_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      last_q <= LastInit;
    end else begin
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  assign hold_req_o    = (state == ARB_ASK) || own;
  assign grant_valid_o = own;
  assign grant_idx_o   = idx_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dack
    assign dack_n_o[g] = !(own && (idx_q == IDX_W'(g)));
  end

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_ack_i,
  input logic              xfer_done_i,
  input logic              hold_req_o,
  input logic [NUM_CH-1:0] dack_n_o,
  input logic              grant_valid_o,
  input logic [IDX_W-1:0]  grant_idx_o,
  input logic [NUM_CH-1:0] chan_en
);

  logic [NUM_CH-1:0] en_prev;

  always_ff @(posedge clk_i) begin
    en_prev <= chan_en;
  end

  // R5: at most one acknowledge low
  a_r5_dack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~dack_n_o) <= 1);

  // R5: granted channel's acknowledge is the low one
  a_r5_dack_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> !dack_n_o[grant_idx_o]);

  // R5: no acknowledge without a grant
  a_r5_dack_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o |-> (&dack_n_o));

  // R4: a new grant only follows a seen acknowledge
  a_r4_grant_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> $past(hold_ack_i));

  // R7: grant frozen until the done strobe
  a_r7_grant_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !xfer_done_i) |=> (grant_valid_o && $stable(grant_idx_o)));

  // R9: no new hold request while acknowledge is still high
  a_r9_no_reraise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_req_o && hold_ack_i) |=> !hold_req_o);

  // R8: a fresh grant goes to an enabled channel
  a_r8_grant_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> en_prev[grant_idx_o]);

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(
  .NUM_CH (NUM_CH),
  .IDX_W  (IDX_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hold_ack_i    (hold_ack_i),
  .xfer_done_i   (xfer_done_i),
  .hold_req_o    (hold_req_o),
  .dack_n_o      (dack_n_o),
  .grant_valid_o (grant_valid_o),
  .grant_idx_o   (grant_idx_o),
  .chan_en       (chan_en)
);

// File: tb/dma_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb_top;

  logic       clk;
  logic       rst_n;
  logic [3:0] dreq;
  logic       mask_load;
  logic [3:0] mask_val;
  logic       rot;
  logic       hold_ack;
  logic       xfer_done;
  logic       hold_req_o;
  logic [3:0] dack_n_o;
  logic       grant_valid_o;
  logic [1:0] grant_idx_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  dma_req_arbiter dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .dreq_i        (dreq),
    .mask_load_i   (mask_load),
    .mask_val_i    (mask_val),
    .rotate_i      (rot),
    .hold_ack_i    (hold_ack),
    .xfer_done_i   (xfer_done),
    .hold_req_o    (hold_req_o),
    .dack_n_o      (dack_n_o),
    .grant_valid_o (grant_valid_o),
    .grant_idx_o   (grant_idx_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference model state: 0 idle, 1 asking, 2 owning, 3 yielding.
  int   m_st;
  int   m_idx;
  int   m_last;
  logic [3:0] m_en;

  // Bench-side processor and sequencer behaviour.
  bit auto_ack;
  int done_len;
  int gcnt;
  bit prev_gv;
  bit prev_done;
  int gq[$];

  function automatic int pick(logic [3:0] m, logic r, int last);
    int s;
    s = r ? (last + 1) % 4 : 0;
    for (int k = 0; k < 4; k++) begin
      if (m[(s + k) % 4]) return (s + k) % 4;
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_idx = 0; m_last = 3; m_en = 4'b0000;
  endtask

  task automatic model_advance();
    logic [3:0] m;
    int nst;
    m = dreq & m_en;
    nst = m_st;
    case (m_st)
      0: if ((m != 0) && !hold_ack) nst = 1;
      1: begin
        if (m == 0) nst = 3;
        else if (hold_ack) begin nst = 2; m_idx = pick(m, rot, m_last); end
      end
      2: begin
        if (xfer_done) begin
          int served;
          served = m_idx;
          m_last = served;
          if (m == 0) nst = 3;
          else if (hold_ack) begin nst = 2; m_idx = pick(m, rot, served); end
          else nst = 1;
        end
      end
      default: if (!hold_ack) nst = 0;
    endcase
    m_st = nst;
    if (mask_load) m_en = mask_val;
  endtask

  task automatic compare();
    logic e_hrq;
    logic e_gv;
    logic [3:0] e_dack;
    e_hrq  = (m_st == 1) || (m_st == 2);
    e_gv   = (m_st == 2);
    e_dack = e_gv ? ~(4'b0001 << m_idx) : 4'b1111;
    chk(hold_req_o === e_hrq, "R4/R9 hold_req", int'(hold_req_o), int'(e_hrq));
    chk(grant_valid_o === e_gv, "R7 grant_valid", int'(grant_valid_o), int'(e_gv));
    chk(dack_n_o === e_dack, "R5 dack_n", int'(dack_n_o), int'(e_dack));
    if (e_gv) begin
      chk(grant_idx_o === 2'(m_idx), rot ? "R3 grant_idx" : "R2 grant_idx",
          int'(grant_idx_o), m_idx);
    end
  endtask

  // One clock: derive processor and sequencer inputs, advance model,
  // cross the edge, compare at the falling edge.
  task automatic step();
    int ngcnt;
    if (auto_ack) hold_ack = hold_req_o;
    xfer_done = grant_valid_o && (gcnt >= done_len - 1);
    ngcnt = (grant_valid_o && !xfer_done) ? gcnt + 1 : 0;
    prev_done = xfer_done;
    prev_gv   = grant_valid_o;
    model_advance();
    @(posedge clk);
    @(negedge clk);
    mask_load = 1'b0;
    gcnt = ngcnt;
    compare();
    if (grant_valid_o && (!prev_gv || prev_done)) gq.push_back(int'(grant_idx_o));
  endtask

  task automatic load_mask(logic [3:0] v);
    mask_load = 1'b1;
    mask_val  = v;
    step();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    int cnt[4];
    rst_n = 1'b0; dreq = '0; mask_load = 1'b0; mask_val = '0; rot = 1'b0;
    hold_ack = 1'b0; xfer_done = 1'b0;
    auto_ack = 1'b1; done_len = 1; gcnt = 0; prev_gv = 0; prev_done = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 / R5: reset state
    chk(hold_req_o === 1'b0, "R6 reset hold_req", int'(hold_req_o), 0);
    chk(dack_n_o === 4'b1111, "R5 reset dack_n", int'(dack_n_o), 15);
    chk(grant_valid_o === 1'b0, "R6 reset grant", int'(grant_valid_o), 0);

    // R6 / R8: all requesting with an empty mask
    dreq = 4'b1111;
    repeat (6) step();
    chk(hold_req_o === 1'b0, "R8 masked requests ignored", int'(hold_req_o), 0);

    // R2 / R10: fixed priority, all requesting, one-cycle transfers
    rot = 1'b0; done_len = 1;
    load_mask(4'b1111);
    gq.delete();
    repeat (4) step();
    for (int i = 0; i < 8; i++) begin
      step();
      chk(grant_valid_o === 1'b1, "R10 back-to-back grant", int'(grant_valid_o), 1);
    end
    chk(gq.size() > 0, "R2 grants seen", gq.size(), 1);
    foreach (gq[i]) chk(gq[i] == 0, "R2 fixed winner", gq[i], 0);

    // R3: rotating order walks one channel at a time
    rot = 1'b1;
    gq.delete();
    repeat (12) step();
    chk(gq.size() >= 5, "R3 grants seen", gq.size(), 5);
    for (int i = 0; i + 1 < gq.size(); i++) begin
      chk(gq[i + 1] == (gq[i] + 1) % 4, "R3 rotation step", gq[i + 1], (gq[i] + 1) % 4);
    end

    // R8: only enabled channels 1 and 3 served, fixed mode picks 1
    rot = 1'b0;
    load_mask(4'b1010);
    gq.delete();
    repeat (10) step();
    foreach (gq[i]) chk(gq[i] == 1, "R8 mask 1010 winner", gq[i], 1);

    // Go idle
    dreq = 4'b0000;
    repeat (6) step();
    load_mask(4'b1111);

    // R4 / R9: handshake driven by hand
    auto_ack = 1'b0; hold_ack = 1'b0;
    dreq = 4'b0100;
    step();
    chk(hold_req_o === 1'b1, "R4 hold_req raised", int'(hold_req_o), 1);
    repeat (3) step();
    chk(dack_n_o === 4'b1111, "R4 no ack no dack", int'(dack_n_o), 15);
    dreq = 4'b0000;
    step();
    chk(hold_req_o === 1'b0, "R9 hold_req dropped", int'(hold_req_o), 0);
    hold_ack = 1'b1;
    dreq = 4'b0100;
    repeat (3) step();
    chk(hold_req_o === 1'b0, "R9 no re-raise while ack high", int'(hold_req_o), 0);
    hold_ack = 1'b0;
    repeat (2) step();
    chk(hold_req_o === 1'b1, "R9 re-raise after ack low", int'(hold_req_o), 1);
    auto_ack = 1'b1;

    // R7: grant held against a higher-priority newcomer
    dreq = 4'b0000;
    repeat (6) step();
    rot = 1'b0; done_len = 6;
    dreq = 4'b0010;
    for (int i = 0; i < 10 && !grant_valid_o; i++) step();
    dreq = 4'b0001;
    load_mask(4'b0001);
    repeat (2) step();
    chk(grant_idx_o === 2'd1 && grant_valid_o, "R7 grant held", int'(grant_idx_o), 1);
    load_mask(4'b1111);
    dreq = 4'b0000;
    repeat (12) step();

    // R1: mixed traffic, rotating, every channel served
    seed = 16'hACE1;
    rot = 1'b1;
    gq.delete();
    for (int i = 0; i < 600; i++) begin
      seed = ((seed >> 1) ^ ((seed & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      dreq = seed[3:0];
      done_len = 1 + (seed[7:5] % 3);
      if (i == 300) rot = 1'b0;
      if (i % 97 == 50) begin mask_load = 1'b1; mask_val = seed[11:8] | 4'b0001; end
      if (i % 97 == 70) begin mask_load = 1'b1; mask_val = 4'b1111; end
      step();
    end
    cnt = '{0, 0, 0, 0};
    foreach (gq[i]) cnt[gq[i]]++;
    for (int c = 0; c < 4; c++) chk(cnt[c] > 0, "R1 channel served", cnt[c], 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule